// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block takes a trap request (a cause code, the faulting program counter and an associated bad address) and decides which privilege level handles it. A trap raised while the hart runs in user or supervisor mode may be handed to supervisor mode when the matching bit of a delegation mask is set. The cause's most significant bit picks the mask: set means an interrupt, clear means an exception. Any other trap goes to machine mode.

On the clock edge that samples the request, the block updates a set of registers together. It loads the redirect program counter and the target level's cause, exception-PC and bad-address registers. It saves the interrupted level's enable bit and privilege into the target level's previous-enable and previous-privilege fields, clears the target's enable bit and switches the privilege. It also emits a one-cycle pulse that releases any load reservation.

A separate context-load port lets the surrounding logic set the privilege and the enable bits. That logic handles return from trap and control-register writes, which this block does not implement. A trap in the same cycle takes precedence over a context load.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, priv is machine (code 3), the enable vector, both previous-enable bits, spp and mpp are 0, all six cause/EPC/bad-address registers are 0, and redirect_valid and resv_release are low.
- R2: The cause's top bit (bit XLEN-1) selects the mask: when it is 1, int_deleg_mask is used and the index is the cause with that bit cleared; when it is 0, exc_deleg_mask is used and the index is the whole cause.
- R3: A trap is delegated only when priv is user (code 0) or supervisor (code 1), the index is below XLEN, and the selected mask bit at that index is 1. A trap taken in machine mode is never delegated, and an index of XLEN or more is never delegated.
- R4: A delegated trap sets priv to supervisor (1) and redirect_pc to stvec with its two low bits cleared. It loads scause with the full cause (top bit included), sepc with trap_epc and sbadaddr with trap_badaddr, and leaves mcause, mepc, mbadaddr, mpie and mpp unchanged.
- R5: A delegated trap sets spie to the enable bit whose index equals the old priv code, sets spp to bit 0 of the old priv and clears enable bit 1. The other enable bits are unchanged.
- R6: An undelegated trap sets priv to machine (3) and redirect_pc to the MTVEC parameter. It loads mcause, mepc and mbadaddr, sets mpie to the enable bit indexed by the old priv, sets mpp to the old priv and clears enable bit 3. The supervisor registers, spie and spp are unchanged.
- R7: redirect_valid and resv_release are high for exactly the one cycle after each cycle with trap_valid high, and low otherwise.
- R8: All trap updates appear at the clock edge that samples trap_valid. In a cycle with neither trap_valid nor ctx_wr, no output register changes.
- R9: ctx_wr loads the enable vector from ctx_ie with bit 2 forced to 0, and loads priv from ctx_priv unless ctx_priv is the reserved code 2. In that case priv is kept. priv never holds code 2.
- R10: When trap_valid and ctx_wr are high in the same cycle, the trap is performed and the context load is discarded entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request strobe |
| trap_cause | input | XLEN | Cause code; top bit marks an interrupt |
| trap_epc | input | XLEN | Program counter of the trapping instruction |
| trap_badaddr | input | XLEN | Faulting address or value |
| exc_deleg_mask | input | XLEN | Exception delegation mask |
| int_deleg_mask | input | XLEN | Interrupt delegation mask |
| stvec | input | XLEN | Supervisor trap vector |
| ctx_wr | input | 1 | Context-load strobe |
| ctx_priv | input | 2 | Privilege to load (U=0, S=1, M=3) |
| ctx_ie | input | 4 | Enable bits to load, indexed by privilege code |
| priv | output | 2 | Current privilege |
| ie | output | 4 | Enable bits; bit n belongs to privilege code n |
| spie | output | 1 | Supervisor previous-enable |
| mpie | output | 1 | Machine previous-enable |
| spp | output | 1 | Supervisor previous privilege |
| mpp | output | 2 | Machine previous privilege |
| redirect_valid | output | 1 | One-cycle pulse: fetch from redirect_pc |
| redirect_pc | output | XLEN | Trap handler address |
| resv_release | output | 1 | One-cycle pulse releasing the load reservation |
| scause | output | XLEN | Supervisor cause register |
| sepc | output | XLEN | Supervisor exception PC |
| sbadaddr | output | XLEN | Supervisor bad address |
| mcause | output | XLEN | Machine cause register |
| mepc | output | XLEN | Machine exception PC |
| mbadaddr | output | XLEN | Machine bad address |

## Verification
A trap request and a context load can fall in the same cycle, and both write the privilege and enable bits. The bench first loads a known context. It then raises trap_valid and ctx_wr together with a conflicting privilege and enable pattern. It judges the outcome against a trap-only model: priv, ie and the saved previous fields must reflect the state before the load, with no trace of the discarded values. A sweep over every legal privilege, all enable patterns, both cause kinds and indices on both sides of XLEN checks the routing decision itself.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  // Enable bits that exist; bit 2 (reserved level) is tied off.
  localparam logic [3:0] IE_LEGAL = 4'b1011;

  // Enable bit belonging to a privilege level.
  function automatic logic enable_of(input logic [3:0] ie_vec, input logic [1:0] lvl);
    return ie_vec[lvl];
  endfunction

  // Only user and supervisor traps may be lowered to supervisor mode.
  function automatic logic may_delegate(input logic [1:0] lvl);
    return (lvl == PRIV_U) || (lvl == PRIV_S);
  endfunction

endpackage

// File: rtl/trap_deleg_decider.sv
module trap_deleg_decider
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cause,
  input  logic [XLEN-1:0] exc_mask,
  input  logic [XLEN-1:0] int_mask,
  input  logic [1:0]      cur_priv,
  output logic            is_intr,
  output logic            idx_in_range,
  output logic            deleg
);
  localparam int IDXW = $clog2(XLEN);
  localparam logic [XLEN-1:0] XLEN_V = XLEN'(XLEN);

  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] sel_mask;
  logic            mask_bit;

  always_comb begin
    is_intr      = cause[XLEN-1];
    idx          = {1'b0, cause[XLEN-2:0]};
    sel_mask     = is_intr ? int_mask : exc_mask;
    idx_in_range = (idx < XLEN_V);
    mask_bit     = sel_mask[idx[IDXW-1:0]];
    deleg        = may_delegate(cur_priv) && idx_in_range && mask_bit;
  end

endmodule

// File: rtl/trap_status_unit.sv
module trap_status_unit
  import trap_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_fire,
  input  logic       deleg,
  input  logic       ctx_wr,
  input  logic [1:0] ctx_priv,
  input  logic [3:0] ctx_ie,
  output logic [1:0] priv_q,
  output logic [3:0] ie_q,
  output logic       spie_q,
  output logic       mpie_q,
  output logic       spp_q,
  output logic [1:0] mpp_q
);
  logic prev_en;
  logic ctx_priv_ok;

  assign prev_en     = enable_of(ie_q, priv_q);
  assign ctx_priv_ok = (ctx_priv != PRIV_RSV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q <= PRIV_M;
      ie_q   <= '0;
      spie_q <= 1'b0;
      mpie_q <= 1'b0;
      spp_q  <= 1'b0;
      mpp_q  <= '0;
    end else if (trap_fire) begin
      if (deleg) begin
        spie_q  <= prev_en;
        spp_q   <= priv_q[0];
        ie_q[1] <= 1'b0;
        priv_q  <= PRIV_S;
      end else begin
        mpie_q  <= prev_en;
        mpp_q   <= priv_q;
        ie_q[3] <= 1'b0;
        priv_q  <= PRIV_M;
      end
    end else if (ctx_wr) begin
      ie_q <= ctx_ie & IE_LEGAL;
      if (ctx_priv_ok) priv_q <= ctx_priv;
    end
  end

  assert_priv_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q != PRIV_RSV);

  assert_ie_rsv_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q[2]);

  assert_mtrap_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire && !deleg |=> priv_q == PRIV_M && !ie_q[3] && mpp_q == $past(priv_q));

  assert_strap_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire && deleg |=> priv_q == PRIV_S && !ie_q[1] && spp_q == $past(priv_q[0]));

  assert_ctx_discarded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire && ctx_wr && !deleg |=> priv_q == PRIV_M);

endmodule

// File: rtl/trap_reg_bank.sv
module trap_reg_bank #(
  parameter int              XLEN  = 32,
  parameter logic [XLEN-1:0] MTVEC = 'h100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_fire,
  input  logic            deleg,
  input  logic [XLEN-1:0] cause,
  input  logic [XLEN-1:0] epc,
  input  logic [XLEN-1:0] badaddr,
  input  logic [XLEN-1:0] stvec,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            resv_release,
  output logic [XLEN-1:0] cause_q [2],
  output logic [XLEN-1:0] epc_q   [2],
  output logic [XLEN-1:0] bad_q   [2]
);
  // Level index 0 = supervisor bank, 1 = machine bank.
  localparam int NLVL = 2;

  logic [NLVL-1:0] lvl_sel;

  genvar g;
  generate
    for (g = 0; g < NLVL; g++) begin : g_lvl
      assign lvl_sel[g] = trap_fire && ((g == 0) ? deleg : !deleg);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cause_q[g] <= '0;
          epc_q[g]   <= '0;
          bad_q[g]   <= '0;
        end else if (lvl_sel[g]) begin
          cause_q[g] <= cause;
          epc_q[g]   <= epc;
          bad_q[g]   <= badaddr;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      resv_release   <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= trap_fire;
      resv_release   <= trap_fire;
      if (trap_fire) redirect_pc <= deleg ? {stvec[XLEN-1:2], 2'b00} : MTVEC;
    end
  end

  assert_one_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lvl_sel) <= 1);

  assert_release_after_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> resv_release && redirect_valid);

  assert_release_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_fire |=> !resv_release && !redirect_valid);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_fire |=> $stable(redirect_pc) && $stable(cause_q[0]) && $stable(cause_q[1]));

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int              XLEN  = 32,
  parameter logic [XLEN-1:0] MTVEC = 'h100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic [XLEN-1:0] trap_badaddr,
  input  logic [XLEN-1:0] exc_deleg_mask,
  input  logic [XLEN-1:0] int_deleg_mask,
  input  logic [XLEN-1:0] stvec,
  input  logic            ctx_wr,
  input  logic [1:0]      ctx_priv,
  input  logic [3:0]      ctx_ie,
  output logic [1:0]      priv,
  output logic [3:0]      ie,
  output logic            spie,
  output logic            mpie,
  output logic            spp,
  output logic [1:0]      mpp,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            resv_release,
  output logic [XLEN-1:0] scause,
  output logic [XLEN-1:0] sepc,
  output logic [XLEN-1:0] sbadaddr,
  output logic [XLEN-1:0] mcause,
  output logic [XLEN-1:0] mepc,
  output logic [XLEN-1:0] mbadaddr
);
  localparam int LVL_S = 0;
  localparam int LVL_M = 1;

  // Named internal events for the assertions.
  logic            ev_trap;
  logic            ev_deleg;
  logic            ev_intr;
  logic            ev_idx_ok;
  logic [XLEN-1:0] cause_arr [2];
  logic [XLEN-1:0] epc_arr   [2];
  logic [XLEN-1:0] bad_arr   [2];

  assign ev_trap = trap_valid;

  trap_deleg_decider #(.XLEN(XLEN)) u_decider (
    .cause        (trap_cause),
    .exc_mask     (exc_deleg_mask),
    .int_mask     (int_deleg_mask),
    .cur_priv     (priv),
    .is_intr      (ev_intr),
    .idx_in_range (ev_idx_ok),
    .deleg        (ev_deleg)
  );

  trap_status_unit u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_fire (ev_trap),
    .deleg     (ev_deleg),
    .ctx_wr    (ctx_wr),
    .ctx_priv  (ctx_priv),
    .ctx_ie    (ctx_ie),
    .priv_q    (priv),
    .ie_q      (ie),
    .spie_q    (spie),
    .mpie_q    (mpie),
    .spp_q     (spp),
    .mpp_q     (mpp)
  );

  trap_reg_bank #(.XLEN(XLEN), .MTVEC(MTVEC)) u_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_fire      (ev_trap),
    .deleg          (ev_deleg),
    .cause          (trap_cause),
    .epc            (trap_epc),
    .badaddr        (trap_badaddr),
    .stvec          (stvec),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .resv_release   (resv_release),
    .cause_q        (cause_arr),
    .epc_q          (epc_arr),
    .bad_q          (bad_arr)
  );

  assign scause   = cause_arr[LVL_S];
  assign sepc     = epc_arr[LVL_S];
  assign sbadaddr = bad_arr[LVL_S];
  assign mcause   = cause_arr[LVL_M];
  assign mepc     = epc_arr[LVL_M];
  assign mbadaddr = bad_arr[LVL_M];

  assert_m_never_deleg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap && priv == PRIV_M |-> !ev_deleg);

  assert_range_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap && !ev_idx_ok |-> !ev_deleg);

  assert_scause_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap && ev_deleg |=> scause[XLEN-1] == $past(ev_intr));

endmodule

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;
  localparam int          XLEN  = 32;
  localparam logic [31:0] MTVEC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic [31:0] trap_cause = '0, trap_epc = '0, trap_badaddr = '0;
  logic [31:0] exc_deleg_mask = '0, int_deleg_mask = '0, stvec = '0;
  logic        ctx_wr = 1'b0;
  logic [1:0]  ctx_priv = '0;
  logic [3:0]  ctx_ie = '0;
  logic [1:0]  priv, mpp;
  logic [3:0]  ie;
  logic        spie, mpie, spp, redirect_valid, resv_release;
  logic [31:0] redirect_pc, scause, sepc, sbadaddr, mcause, mepc, mbadaddr;

  always #2.5 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .MTVEC(MTVEC)) i_trap_entry_unit (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Bench-side model of the architectural state.
  logic [1:0]  e_priv = 2'd3, e_mpp = 2'd0;
  logic [3:0]  e_ie = 4'd0;
  logic        e_spie = 0, e_mpie = 0, e_spp = 0;
  logic [31:0] e_pc = 0, e_sc = 0, e_se = 0, e_sb = 0, e_mc = 0, e_me = 0, e_mb = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string ctx, input bit pulse);
    chk({ctx, " R4_R6 priv"}, 64'(priv), 64'(e_priv));
    chk({ctx, " R5_R6_R9 ie"}, 64'(ie), 64'(e_ie));
    chk({ctx, " R5 spie"}, 64'(spie), 64'(e_spie));
    chk({ctx, " R5 spp"}, 64'(spp), 64'(e_spp));
    chk({ctx, " R6 mpie"}, 64'(mpie), 64'(e_mpie));
    chk({ctx, " R6 mpp"}, 64'(mpp), 64'(e_mpp));
    chk({ctx, " R4_R6 redirect_pc"}, 64'(redirect_pc), 64'(e_pc));
    chk({ctx, " R4 scause"}, 64'(scause), 64'(e_sc));
    chk({ctx, " R4 sepc"}, 64'(sepc), 64'(e_se));
    chk({ctx, " R4 sbadaddr"}, 64'(sbadaddr), 64'(e_sb));
    chk({ctx, " R6 mcause"}, 64'(mcause), 64'(e_mc));
    chk({ctx, " R6 mepc"}, 64'(mepc), 64'(e_me));
    chk({ctx, " R6 mbadaddr"}, 64'(mbadaddr), 64'(e_mb));
    chk({ctx, " R7 redirect_valid"}, 64'(redirect_valid), 64'(pulse));
    chk({ctx, " R7 resv_release"}, 64'(resv_release), 64'(pulse));
  endtask

  // Expected routing, computed arithmetically from R2/R3.
  function automatic bit expect_deleg(input logic [31:0] c, input logic [1:0] p);
    longint unsigned idx = longint'(c) % (64'd1 << 31);
    longint unsigned m = c[31] ? longint'(int_deleg_mask) : longint'(exc_deleg_mask);
    bit low = (p == 2'd0) || (p == 2'd1);
    return low && (idx < 32) && (((m >> idx) & 1) == 1);
  endfunction

  task automatic model_trap(input logic [31:0] c, input logic [31:0] pc, input logic [31:0] bad);
    bit d = expect_deleg(c, e_priv);
    logic prev = e_ie[e_priv];
    if (d) begin
      e_spie = prev; e_spp = e_priv[0]; e_ie[1] = 1'b0; e_priv = 2'd1;
      e_pc = stvec & 32'hFFFF_FFFC; e_sc = c; e_se = pc; e_sb = bad;
    end else begin
      e_mpie = prev; e_mpp = e_priv; e_ie[3] = 1'b0; e_priv = 2'd3;
      e_pc = MTVEC; e_mc = c; e_me = pc; e_mb = bad;
    end
  endtask

  task automatic set_ctx(input logic [1:0] p, input logic [3:0] v);
    @(negedge clk);
    ctx_wr = 1'b1; ctx_priv = p; ctx_ie = v;
    if (p != 2'd2) e_priv = p;
    e_ie = v & 4'b1011;
  endtask

  task automatic do_trap(input string ctx, input logic [31:0] c, input logic [31:0] pc,
                         input logic [31:0] bad, input bit with_ctx,
                         input logic [1:0] cp, input logic [3:0] cv);
    @(negedge clk);
    trap_valid = 1'b1; trap_cause = c; trap_epc = pc; trap_badaddr = bad;
    ctx_wr = with_ctx; ctx_priv = cp; ctx_ie = cv;
    model_trap(c, pc, bad);
    @(negedge clk);
    trap_valid = 1'b0; ctx_wr = 1'b0;
    check_state(ctx, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("reset R1", 1'b0);

    // Sweep: every legal privilege, all enable patterns, both cause kinds,
    // indices straddling XLEN (R2, R3, R4, R5, R6, R7, R8).
    for (int pi = 0; pi < 3; pi++) begin
      for (int e = 0; e < 8; e++) begin
        exc_deleg_mask = e[0] ? 32'hA5C3_0F69 : 32'h5A3C_F096;
        int_deleg_mask = e[1] ? 32'h8000_0222 : 32'h7FFF_FDDD;
        for (int k = 0; k < 2; k++) begin
          for (int idx = 0; idx < 36; idx++) begin
            logic [1:0] p = (pi == 2) ? 2'd3 : 2'(pi);
            logic [3:0] v = {e[2], 1'b0, e[1], e[0]};
            logic [31:0] c = {k[0], 31'(idx)};
            stvec = 32'h8000_1003 + 32'(idx * 64);
            set_ctx(p, v);
            do_trap("sweep R2_R3", c, 32'h1000 + 32'(idx * 4), 32'hBAD0_0000 + 32'(idx), 1'b0, 2'd0, 4'd0);
          end
        end
      end
    end

    // R8: idle cycles change nothing and pulses drop.
    @(negedge clk);
    check_state("idle R8", 1'b0);
    @(negedge clk);
    check_state("idle2 R8", 1'b0);

    // R3 boundary: index XLEN-1 delegates, huge index does not.
    exc_deleg_mask = 32'hFFFF_FFFF;
    stvec = 32'h0000_4000;
    set_ctx(2'd0, 4'b0001);
    do_trap("idx31 R3", 32'h0000_001F, 32'h44, 32'h55, 1'b0, 2'd0, 4'd0);
    chk("idx31 R3 delegated", 64'(priv), 64'd1);
    set_ctx(2'd0, 4'b0001);
    do_trap("idxbig R3", 32'h7FFF_FFFF, 32'h48, 32'h59, 1'b0, 2'd0, 4'd0);
    chk("idxbig R3 to machine", 64'(priv), 64'd3);

    // R9: reserved privilege code ignored, enable bit 2 dropped.
    set_ctx(2'd1, 4'b0000);
    set_ctx(2'd2, 4'b1111);
    @(negedge clk);
    ctx_wr = 1'b0;
    check_state("ctx R9", 1'b0);
    chk("ctx R9 priv kept", 64'(priv), 64'd1);
    chk("ctx R9 ie bit2", 64'(ie[2]), 64'd0);

    // R10: trap and context load in the same cycle.
    exc_deleg_mask = 32'h0000_0004;
    set_ctx(2'd0, 4'b1001);
    do_trap("collide R10 deleg", 32'h0000_0002, 32'h80, 32'h90, 1'b1, 2'd3, 4'b0110);
    chk("collide R10 priv", 64'(priv), 64'd1);
    set_ctx(2'd1, 4'b0010);
    do_trap("collide R10 mach", 32'h0000_0005, 32'h84, 32'h94, 1'b1, 2'd0, 4'b1011);
    chk("collide R10 ie", 64'(ie), 64'd2);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule